// File: doc/BRIEF.md
# Command-Driven Address Wrap Gate Controller

This block models a small legacy peripheral controller that owns the gate deciding whether address bit 20 is passed to memory or forced low, which makes addresses past the first megabyte wrap back to zero. The host never writes the gate directly. It talks to the controller through two byte-wide I/O locations: a command location that also reads back status, and a data location. The gate is bit 1 of an internal output-port register. Two commands reach that register. One copies it into an output buffer that the host reads from the data location. The other arms the controller so that the next data byte replaces the register.

Each accepted byte marks the input buffer full. The byte is then processed after a programmable delay, which stands in for the controller's internal firmware time. A host is expected to poll the status byte before every write and before every data read. Changing only the gate bit is therefore a read-modify-write sequence made of four handshaked transfers.

Top module: `legacy_gate_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the output-port register holds OUTPORT_RST (bit 1 clear by elaboration check), and `gate_en` is low.
- R2: A read with `cs` high at address CMD_ADDR returns the status byte: bit 1 is the input-buffer-full flag, bit 0 is the output-buffer-full flag, and bits 7..2 are zero.
- R3: A write with `cs` high at CMD_ADDR or DATA_ADDR while the input buffer is empty sets input-buffer-full for exactly BUSY_CYC clock cycles, and the byte takes effect on the edge that clears the flag.
- R4: A write that arrives while input-buffer-full is set is dropped and leaves no trace.
- R5: Command 0xD0 copies the output-port register into the output buffer and sets output-buffer-full when it is processed.
- R6: A read at DATA_ADDR returns the output buffer in the same cycle and clears output-buffer-full on the following edge.
- R7: Command 0xD1 makes the next processed data byte replace the output-port register, and `gate_en` then equals bit 1 of that byte.
- R8: A data byte processed without a pending 0xD1 is discarded and leaves the output-port register unchanged.
- R9: Any processed command other than 0xD0 and 0xD1 is discarded and cancels a pending 0xD1.
- R10: Strobes with `cs` low or at any other address have no effect, and `rdata` is 0x00 whenever no read is being decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Bus select for this controller |
| addr | input | ADDR_W | I/O address |
| rd | input | 1 | Read strobe, one cycle per byte |
| wr | input | 1 | Write strobe, one cycle per byte |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid in the cycle `rd` is high |
| gate_en | output | 1 | Address bit 20 gate enable |

## Verification
The hardest situation to reach is a write that collides with a byte still being processed. A host that follows the polling discipline never produces it. The bench therefore issues a second command on the cycle right after the first, with no status poll in between. It then proves the collision was dropped through later behaviour: the dropped 0xD1 must not arm the controller, so a following data byte must leave the gate unchanged. The same indirect approach shows that a pending 0xD1 is cancelled by an unknown command, because a stale data byte must not reach the gate.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
   localparam int BYTE_W = 8;

   // command codes recognised by the engine
   localparam logic [BYTE_W-1:0] CMD_RD_PORT = 8'hD0;
   localparam logic [BYTE_W-1:0] CMD_WR_PORT = 8'hD1;

   // status byte bit positions
   localparam int ST_IN_FULL  = 1;
   localparam int ST_OUT_FULL = 0;

   typedef enum logic [1:0] {
      ACT_NONE,
      ACT_LOAD_OBUF,
      ACT_ARM,
      ACT_STORE_PORT
   } act_e;

   typedef struct packed {
      logic              is_cmd;
      logic [BYTE_W-1:0] val;
   } in_entry_t;
endpackage

// File: rtl/kbc_host_if.sv
module kbc_host_if
   import kbc_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h64,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h60
) (
   input  logic              cs,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              in_full,
   input  logic              out_full,
   input  logic [BYTE_W-1:0] obuf,
   output logic              wr_take,
   output logic              wr_is_cmd,
   output logic              rd_pop,
   output logic [BYTE_W-1:0] rdata
);
   logic hit_cmd, hit_data;

   assign hit_cmd   = cs && (addr == CMD_ADDR);
   assign hit_data  = cs && (addr == DATA_ADDR);
   assign wr_take   = wr && (hit_cmd || hit_data) && !in_full;
   assign wr_is_cmd = hit_cmd;
   assign rd_pop    = rd && hit_data;

   always_comb begin
      rdata = '0;
      if (rd && hit_cmd) begin
         rdata[ST_IN_FULL]  = in_full;
         rdata[ST_OUT_FULL] = out_full;
      end else if (rd && hit_data) begin
         rdata = obuf;
      end
   end
endmodule

// File: rtl/kbc_busy_timer.sv
module kbc_busy_timer #(
   parameter int BUSY_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   generate
      if (BUSY_CYC == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     busy <= 1'b0;
            else if (start) busy <= 1'b1;
            else if (busy)  busy <= 1'b0;
         end
         assign done = busy;
      end else begin : g_count
         localparam int CNT_W = $clog2(BUSY_CYC);
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYC - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy <= 1'b0;
               cnt  <= '0;
            end else if (start) begin
               busy <= 1'b1;
               cnt  <= LOAD;
            end else if (busy) begin
               if (cnt == '0) busy <= 1'b0;
               else           cnt  <= cnt - 1'b1;
            end
         end
         assign done = busy && (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
   import kbc_pkg::*;
#(
   parameter logic [BYTE_W-1:0] OUTPORT_RST = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              take_is_cmd,
   input  logic [BYTE_W-1:0] take_val,
   input  logic              done,
   input  logic              pop,
   output logic [BYTE_W-1:0] outport,
   output logic [BYTE_W-1:0] obuf,
   output logic              out_full
);
   in_entry_t held;
   logic      armed;
   act_e      act;

   function automatic act_e decode(input in_entry_t e, input logic arm);
      if (e.is_cmd) begin
         if (e.val == CMD_RD_PORT)      return ACT_LOAD_OBUF;
         else if (e.val == CMD_WR_PORT) return ACT_ARM;
         else                           return ACT_NONE;
      end
      return arm ? ACT_STORE_PORT : ACT_NONE;
   endfunction

   assign act = done ? decode(held, armed) : ACT_NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= '0;
      else if (take) held <= '{is_cmd: take_is_cmd, val: take_val};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         outport <= OUTPORT_RST;
      end else if (done) begin
         // every processed byte settles the armed state
         armed <= (act == ACT_ARM);
         if (act == ACT_STORE_PORT) outport <= held.val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obuf     <= '0;
         out_full <= 1'b0;
      end else if (act == ACT_LOAD_OBUF) begin
         obuf     <= outport;
         out_full <= 1'b1;
      end else if (pop) begin
         out_full <= 1'b0;
      end
   end
endmodule

// File: rtl/legacy_gate_ctrl.sv
module legacy_gate_ctrl
   import kbc_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] CMD_ADDR    = 8'h64,
   parameter logic [ADDR_W-1:0] DATA_ADDR   = 8'h60,
   parameter int                BUSY_CYC    = 4,
   parameter logic [7:0]        OUTPORT_RST = 8'h01,
   parameter int                GATE_BIT    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              gate_en
);
   initial begin
      if (BUSY_CYC < 1)            $error("BUSY_CYC must be at least 1");
      if (CMD_ADDR == DATA_ADDR)   $error("port addresses must differ");
      if (GATE_BIT >= BYTE_W)      $error("GATE_BIT out of range");
      if (OUTPORT_RST[GATE_BIT])   $error("gate must reset disabled");
   end

   logic              in_full, out_full, done;
   logic              wr_take, wr_is_cmd, rd_pop;
   logic [BYTE_W-1:0] outport, obuf;

   kbc_host_if #(
      .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)
   ) u_if (
      .cs(cs), .addr(addr), .rd(rd), .wr(wr),
      .in_full(in_full), .out_full(out_full), .obuf(obuf),
      .wr_take(wr_take), .wr_is_cmd(wr_is_cmd), .rd_pop(rd_pop),
      .rdata(rdata)
   );

   kbc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(wr_take),
      .busy(in_full), .done(done)
   );

   kbc_cmd_engine #(.OUTPORT_RST(OUTPORT_RST)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .take(wr_take), .take_is_cmd(wr_is_cmd), .take_val(wdata),
      .done(done), .pop(rd_pop),
      .outport(outport), .obuf(obuf), .out_full(out_full)
   );

   assign gate_en = outport[GATE_BIT];
endmodule

// File: rtl/kbc_gate_chk.sv
module kbc_gate_chk #(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h64,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h60,
   parameter int                BUSY_CYC  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic [ADDR_W-1:0] addr,
   input logic              rd,
   input logic              wr,
   input logic [7:0]        rdata,
   input logic              gate_en,
   input logic              in_full,
   input logic              out_full
);
   localparam int RUN_W = $clog2(BUSY_CYC + 2);
   logic [RUN_W-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run <= '0;
      else if (in_full) run <= run + 1'b1;
      else              run <= '0;
   end

   a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run <= RUN_W'(BUSY_CYC));
   a_r3_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_full) |-> run == RUN_W'(BUSY_CYC));
   a_r3_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_full) |-> $past(wr && cs));
   a_r7_gate_on_consume: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gate_en) |-> $fell(in_full));
   a_r5_fill_on_consume: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_full) |-> $fell(in_full));
   a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_full) |-> $past(rd && cs && addr == DATA_ADDR));
   a_r2_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && cs && addr == CMD_ADDR) |-> rdata[7:2] == 6'd0);
   a_r10_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && cs) |-> rdata == 8'h00);
endmodule

bind legacy_gate_ctrl kbc_gate_chk #(
   .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR), .BUSY_CYC(BUSY_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
   .rdata(rdata), .gate_en(gate_en), .in_full(in_full), .out_full(out_full)
);

// File: tb/sim_legacy_gate_ctrl.sv
`timescale 1ns/1ps
module sim_legacy_gate_ctrl;
   localparam int         BUSY  = 4;
   localparam logic [7:0] PCMD  = 8'h64;
   localparam logic [7:0] PDAT  = 8'h60;
   localparam logic [7:0] PRST  = 8'h01;

   localparam logic [3:0] OP_WCMD = 4'd0, OP_WDAT = 4'd1, OP_WAIT = 4'd2,
                          OP_STAT = 4'd3, OP_RDAT = 4'd4, OP_GATE = 4'd5;
   localparam int NV = 37;
   // {op, requirement number, byte}
   localparam logic [15:0] VEC [NV] = '{
      {OP_STAT,4'd1,8'h00}, {OP_GATE,4'd1,8'h00},                       // R1
      {OP_WCMD,4'd5,8'hD0}, {OP_WAIT,4'd0,8'h00}, {OP_STAT,4'd5,8'h01},  // R5
      {OP_RDAT,4'd5,PRST},  {OP_STAT,4'd6,8'h00},                        // R6
      {OP_WCMD,4'd7,8'hD1}, {OP_WAIT,4'd0,8'h00}, {OP_WDAT,4'd7,8'h03},  // R7
      {OP_WAIT,4'd0,8'h00}, {OP_GATE,4'd7,8'h01}, {OP_WCMD,4'd7,8'hD0},
      {OP_WAIT,4'd0,8'h00}, {OP_RDAT,4'd7,8'h03},
      {OP_WDAT,4'd8,8'h00}, {OP_WAIT,4'd0,8'h00}, {OP_GATE,4'd8,8'h01},  // R8
      {OP_WCMD,4'd8,8'hD0}, {OP_WAIT,4'd0,8'h00}, {OP_RDAT,4'd8,8'h03},
      {OP_WCMD,4'd9,8'hD1}, {OP_WAIT,4'd0,8'h00}, {OP_WCMD,4'd9,8'h55},  // R9
      {OP_WAIT,4'd0,8'h00}, {OP_WDAT,4'd9,8'h00}, {OP_WAIT,4'd0,8'h00},
      {OP_GATE,4'd9,8'h01}, {OP_STAT,4'd9,8'h00},
      {OP_WCMD,4'd7,8'hD1}, {OP_WAIT,4'd0,8'h00}, {OP_WDAT,4'd7,8'hFC},
      {OP_WAIT,4'd0,8'h00}, {OP_GATE,4'd7,8'h00}, {OP_WCMD,4'd7,8'hD0},
      {OP_WAIT,4'd0,8'h00}, {OP_RDAT,4'd7,8'hFC}
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic [7:0] rdata;
   logic       gate_en;
   int checks = 0, failures = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   legacy_gate_ctrl #(
      .BUSY_CYC(BUSY), .CMD_ADDR(PCMD), .DATA_ADDR(PDAT), .OUTPORT_RST(PRST)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
      .wdata(wdata), .rdata(rdata), .gate_en(gate_en)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic raw_write(input logic c, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cs = c; addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
   endtask

   // status peek: no clock edge passes while rd is high
   task automatic peek(input logic [7:0] a, output logic [7:0] v);
      cs = 1'b1; addr = a; rd = 1'b1;
      #1 v = rdata;
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic read_data(output logic [7:0] v);
      @(negedge clk);
      cs = 1'b1; addr = PDAT; rd = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic settle();
      repeat (BUSY + 1) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int i = 0; i < NV; i++) begin
         automatic logic [3:0] op  = VEC[i][15:12];
         automatic string      req = $sformatf("R%0d", VEC[i][11:8]);
         automatic logic [7:0] b   = VEC[i][7:0];
         case (op)
            OP_WCMD: raw_write(1'b1, PCMD, b);
            OP_WDAT: raw_write(1'b1, PDAT, b);
            OP_WAIT: settle();
            OP_STAT: begin @(negedge clk); peek(PCMD, v); check(req, v, b); end
            OP_RDAT: begin read_data(v); check(req, v, b); end
            default: begin @(negedge clk); check(req, {7'd0, gate_en}, b); end
         endcase
      end

      // R3: busy window length, sampled after each edge
      raw_write(1'b1, PCMD, 8'h55);
      for (int k = 0; k < BUSY; k++) begin
         peek(PCMD, v); check("R3 busy", v, 8'h02);
         @(negedge clk);
      end
      peek(PCMD, v); check("R3 release", v, 8'h00);

      // R2: both flags visible together
      raw_write(1'b1, PCMD, 8'hD0);
      settle();
      raw_write(1'b1, PCMD, 8'h55);
      peek(PCMD, v); check("R2 both flags", v, 8'h03);
      settle();
      read_data(v); check("R6 read", v, 8'hFC);
      peek(PCMD, v); check("R6 cleared", v, 8'h00);

      // R4: back-to-back write while busy is dropped
      raw_write(1'b1, PCMD, 8'hD0);
      raw_write(1'b1, PCMD, 8'hD1);
      settle();
      peek(PCMD, v); check("R4 first kept", v, 8'h01);
      read_data(v); check("R4 data", v, 8'hFC);
      raw_write(1'b1, PDAT, 8'h02);
      settle();
      check("R4 no arm", {7'd0, gate_en}, 8'h00);

      // R10: deselected or foreign address has no effect
      raw_write(1'b0, PCMD, 8'hD1);
      raw_write(1'b1, 8'h61, 8'hD1);
      peek(PCMD, v); check("R10 no busy", v, 8'h00);
      settle();
      raw_write(1'b1, PDAT, 8'h02);
      settle();
      check("R10 gate", {7'd0, gate_en}, 8'h00);
      peek(8'h61, v); check("R10 foreign read", v, 8'h00);

      // R1: reset in mid run returns gate to disabled
      raw_write(1'b1, PCMD, 8'hD1);
      settle();
      raw_write(1'b1, PDAT, 8'h02);
      settle();
      check("R7 gate set", {7'd0, gate_en}, 8'h01);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 gate reset", {7'd0, gate_en}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      peek(PCMD, v); check("R1 status reset", v, 8'h00);
      raw_write(1'b1, PCMD, 8'hD0);
      settle();
      read_data(v); check("R1 port reset value", v, PRST);

      finish_run();
   end
endmodule